// File: doc/BRIEF.md
# Multi-Rail Power-Good Generator with Minimum Low Time

This block drives one power-good flag for each regulated rail, four by default. Each rail supplies two comparator results. One says the output has reached the upper threshold, which is 96% of target. The other says the output has fallen under the lower threshold, which is 93% of target. The block turns these into a clean flag with hysteresis between the two thresholds. The rail's own enable and a shared fault-forcing input can also pull the flag low.

Each time a flag drops, a per-rail hold-off counter keeps it low for a minimum number of timebase ticks. The default is 50,000 ticks of a 1 MHz strobe, which gives 50 ms. The flag comes back only when three things are true: the hold has run out, no low cause remains, and the output sits above the upper threshold. A low cause that lasts longer than the hold therefore releases as soon as it clears and the output is settled. No second hold-off is added after it.

Top module: `pgood_gen`

## Requirements
- R1: A low flag rises only on a clock edge at which the rail's upper-threshold input is high, its hold counter is already zero and no low cause is present. A low cause is any of: enable low, global fault high, or the lower-threshold input high.
- R2: While the flag is high, it stays high when both threshold inputs are low. It falls on the next edge after the lower-threshold input goes high.
- R3: After every drop the flag stays low for at least HOLD_TICKS tick strobes. With the tick high on every cycle and no cause present, the drop edge is followed by HOLD_TICKS low edges, and the flag rises on the edge after those.
- R4: A low level on a rail's enable forces that rail's flag low on the next clock edge.
- R5: A high level on the global fault input forces every flag low on the next clock edge.
- R6: When a new low cause starts during a hold, the counter is reloaded to the full HOLD_TICKS.
- R7: A cause that outlasts the hold releases the flag one edge after the cause clears, provided the upper-threshold input is high.
- R8: Reset makes every flag low and loads every hold counter with HOLD_TICKS, as if a drop had just occurred.
- R9: The rails are independent. A cause on one rail leaves the other rails' flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe that advances the hold counters |
| fault_force | input | 1 | Global fault: pulls every flag low while high |
| rail_en | input | NUM_RAILS | Per-rail enable, high = rail on |
| above_hi | input | NUM_RAILS | Per-rail output at or above upper threshold (96%) |
| below_lo | input | NUM_RAILS | Per-rail output under lower threshold (93%) |
| pgood | output | NUM_RAILS | Per-rail power-good flag |

## Verification
The assertions assume that the threshold inputs are already synchronous to clk. They also assume that tick is a single-cycle strobe. They do not assume that the two threshold inputs of a rail are mutually exclusive, because the block gives the lower-threshold input priority in every case. The bench drives every input on the falling clock edge from one place. It runs a small hold length so that full hold windows, reloads in the middle of a hold, and long causes fit into short runs. The random sweep spans every combination of the inputs, including both threshold inputs high together and irregular tick strobes.

// File: rtl/pg_pkg.sv
package pg_pkg;

  // Next flag value: a high flag survives while no cause exists;
  // a low flag rises only with an expired hold, no cause and a settled output.
  function automatic logic pg_next_state(input logic pg_now,
                                         input logic cause,
                                         input logic expired,
                                         input logic settled);
    if (pg_now) return !cause;
    return expired && !cause && settled;
  endfunction

  // A cause is anything that must hold the flag low.
  function automatic logic pg_cause(input logic en,
                                    input logic fault,
                                    input logic under);
    return !en || fault || under;
  endfunction

endpackage

// File: rtl/pg_holdoff.sv
module pg_holdoff #(
  parameter int HOLD_TICKS = 50000,
  parameter int CNT_W      = $clog2(HOLD_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cause,
  output logic             expired,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_TICKS);

  logic cause_q;
  logic cause_rise;

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c,
                                                input logic reload,
                                                input logic stb);
    if (reload) return HOLD_V;
    if (stb && c != '0) return c - 1'b1;
    return c;
  endfunction

  assign cause_rise = cause && !cause_q;
  assign expired    = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= HOLD_V;
      cause_q <= 1'b1;
    end else begin
      count   <= cnt_next(count, cause_rise, tick);
      cause_q <= cause;
    end
  end

  AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    cause_rise |=> count == HOLD_V); // R6

  AST_NO_EARLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cause_rise) |=> $stable(count)); // R3

endmodule

// File: rtl/pg_rail.sv
module pg_rail
  import pg_pkg::*;
#(
  parameter int HOLD_TICKS = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic fault,
  input  logic above_hi,
  input  logic below_lo,
  output logic pgood
);

  localparam int CNT_W = $clog2(HOLD_TICKS + 1);

  logic             cause;
  logic             hold_expired;
  logic [CNT_W-1:0] hold_count;

  assign cause = pg_cause(en, fault, below_lo);

  pg_holdoff #(.HOLD_TICKS(HOLD_TICKS), .CNT_W(CNT_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .cause   (cause),
    .expired (hold_expired),
    .count   (hold_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pgood <= 1'b0;
    else        pgood <= pg_next_state(pgood, cause, hold_expired, above_hi);
  end

  AST_RISE_NEEDS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (!pgood && !above_hi) |=> !pgood); // R1

  AST_HYST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pgood && !below_lo && en && !fault) |=> pgood); // R2

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_expired |-> !pgood); // R3

  AST_EN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pgood); // R4

  AST_FAULT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !pgood); // R5

endmodule

// File: rtl/pgood_gen.sv
module pgood_gen #(
  parameter int NUM_RAILS  = 4,
  parameter int HOLD_TICKS = 50000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 fault_force,
  input  logic [NUM_RAILS-1:0] rail_en,
  input  logic [NUM_RAILS-1:0] above_hi,
  input  logic [NUM_RAILS-1:0] below_lo,
  output logic [NUM_RAILS-1:0] pgood
);

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    pg_rail #(.HOLD_TICKS(HOLD_TICKS)) u_rail (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .en       (rail_en[r]),
      .fault    (fault_force),
      .above_hi (above_hi[r]),
      .below_lo (below_lo[r]),
      .pgood    (pgood[r])
    );
  end

  AST_FAULT_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fault_force |=> pgood == '0); // R5

endmodule

// File: tb/pgood_gen_test.sv
`timescale 1ns/1ps
module pgood_gen_test;

  localparam int N = 4;
  localparam int H = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b1;
  logic         fault_force = 1'b0;
  logic [N-1:0] rail_en = '1;
  logic [N-1:0] above_hi = '1;
  logic [N-1:0] below_lo = '0;
  logic [N-1:0] pgood;

  int checks = 0;
  int failures = 0;
  string phase = "R8";

  // Reference state built from the requirements.
  logic m_pg [N];
  int   m_cnt [N];
  logic m_prev_cause [N];

  pgood_gen #(.NUM_RAILS(N), .HOLD_TICKS(H)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fault_force(fault_force),
    .rail_en(rail_en), .above_hi(above_hi), .below_lo(below_lo), .pgood(pgood)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: pgood=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < N; r++) begin
      m_pg[r] = 1'b0; m_cnt[r] = H; m_prev_cause[r] = 1'b1;
    end
  endtask

  function automatic logic [N-1:0] model_vec();
    logic [N-1:0] v;
    for (int r = 0; r < N; r++) v[r] = m_pg[r];
    return v;
  endfunction

  // One clock: the edge applies the current inputs, then compare at the falling edge.
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      for (int r = 0; r < N; r++) begin
        logic c;
        int   old_cnt;
        c = !rail_en[r] || fault_force || below_lo[r];
        old_cnt = m_cnt[r];
        if (c && !m_prev_cause[r]) m_cnt[r] = H;
        else if (tick && m_cnt[r] > 0) m_cnt[r] = m_cnt[r] - 1;
        if (m_pg[r]) m_pg[r] = !c;
        else m_pg[r] = (old_cnt == 0) && !c && above_hi[r];
        m_prev_cause[r] = c;
      end
      @(negedge clk);
      check(phase, pgood, model_vec());
    end
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R8", pgood, '0);
    rst_n = 1'b1;
    phase = "R8";
    step(H);
    check("R8", pgood, '0);              // still held after H ticks
    step(1);
    check("R8", pgood, '1);              // rises on the next edge

    // R3: one-cycle under-threshold pulse on rail 0
    phase = "R3";
    below_lo[0] = 1'b1; step(1);
    check("R3", pgood, 4'b1110);
    below_lo[0] = 1'b0; step(H);
    check("R3", pgood[0] ? 4'hF : 4'b1110, 4'b1110);
    step(1);
    check("R3", pgood, '1);

    // R2: both thresholds low keeps flag high
    phase = "R2";
    above_hi = '0; step(5);
    check("R2", pgood, '1);
    above_hi = '1; step(1);

    // R1: flag cannot rise without upper threshold
    phase = "R1";
    below_lo[1] = 1'b1; step(1);
    below_lo[1] = 1'b0; above_hi[1] = 1'b0; step(H + 4);
    check("R1", pgood, 4'b1101);
    above_hi[1] = 1'b1; step(1);
    check("R1", pgood, '1);

    // R6: a new cause in mid-hold reloads the count
    phase = "R6";
    below_lo[2] = 1'b1; step(1);
    below_lo[2] = 1'b0; step(3);
    below_lo[2] = 1'b1; step(1);
    below_lo[2] = 1'b0; step(H);
    check("R6", pgood, 4'b1011);
    step(1);
    check("R6", pgood, '1);

    // R7: cause longer than hold releases one edge after clearing
    phase = "R7";
    below_lo[3] = 1'b1; step(H + 10);
    check("R7", pgood, 4'b0111);
    below_lo[3] = 1'b0; step(1);
    check("R7", pgood, '1);

    // R4: enable loss
    phase = "R4";
    rail_en[1] = 1'b0; step(1);
    check("R4", pgood, 4'b1101);
    rail_en[1] = 1'b1; step(H + 1);
    check("R4", pgood, '1);

    // R5: global fault
    phase = "R5";
    fault_force = 1'b1; step(1);
    check("R5", pgood, '0);
    fault_force = 1'b0; step(H + 1);
    check("R5", pgood, '1);

    // R9: random sweep, all rails independent, irregular ticks
    phase = "R9";
    for (int i = 0; i < 3000; i++) begin
      tick        = ($urandom_range(0, 2) != 0);
      fault_force = ($urandom_range(0, 40) == 0);
      for (int r = 0; r < N; r++) begin
        rail_en[r]  = ($urandom_range(0, 30) != 0);
        below_lo[r] = ($urandom_range(0, 15) == 0);
        above_hi[r] = ($urandom_range(0, 4) != 0);
      end
      step(1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule